// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block connects a fast bus clock domain to a slow, free-running timer clock, such as a 32.768 kHz crystal, that has no phase relation to the bus. It holds five timer registers: an 8-bit count, two compare values and two control bytes. A bus write first lands in a holding register that belongs to that register alone. The value then crosses into the timer domain through a toggle handshake and takes effect on the second rising timer edge. Each register shows its own busy bit in a status byte while its transfer is in flight.

In the timer domain a simple up-counter runs while a committed run bit is set. It raises overflow and compare events. Each event crosses back to the bus domain as a toggle. There it sets a sticky flag, which software clears by writing one to the flag bit. Per-flag enable bits combine the flags into one interrupt line. A write to a register whose busy bit is still set is dropped and recorded in a sticky collision bit.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset every register, holding register, flag, enable, busy bit and the collision bit read zero, the count is zero and stopped, and `irq` is low.
- R2: The address map is 0 count, 1 compare A, 2 compare B, 3 control A, 4 control B, 5 status, 6 flags, 7 enables. Status bit i (i = 0..4) is the busy bit of address i, and status bit 5 is the collision bit. Flag and enable bit 0 is overflow, bit 1 is compare A and bit 2 is compare B. Reading address 0 returns the live timer-domain count. Reading addresses 1 to 4 returns the holding register.
- R3: A write to addresses 0 to 4 whose busy bit is clear loads the holding register. The busy bit reads one from the next bus cycle.
- R4: The written value takes effect in the timer domain on the second rising timer edge after the write. The busy bit clears within three bus cycles after that edge, which is before the third timer edge.
- R5: A write to a register whose busy bit is set is ignored, and the holding register keeps its value. It sets the collision bit. That bit stays set until a one is written to status bit 5.
- R6: A pending write to one register never disturbs a pending or committed value of another register.
- R7: The count rises by one on each timer edge while the committed control A bit 0 is one. Otherwise it holds. A committed count write replaces the count at its commit edge, and no increment happens on that edge.
- R8: The overflow flag is set when the count steps from 255 to 0.
- R9: Compare flag A or B is set when a step makes the count equal the committed compare value. No compare flag is raised on a timer edge that commits a count or compare write.
- R10: An event is visible as a flag within four bus cycles of its timer edge. Flags are sticky, and writing one to a flag bit clears only that flag.
- R11: `irq` is high exactly when some flag is set together with its enable bit.
- R12: With committed control B bit 0 set, the step after the count equals compare A returns the count to 0 instead of incrementing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| tclk | input | 1 | Asynchronous timer clock, more than four times slower than clk |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Read data, combinational from rd_addr |
| irq | output | 1 | Enabled flag present |

## Verification
A busy bit is due one bus cycle after its write. The commit is due on the second timer edge after the write. The bench counts timer edges from the bus edge that captured the write to the bus cycle in which busy reads zero, and expects exactly two. Counter and flag results are due on a timer edge plus up to four bus cycles. The bench therefore waits for a timer edge, then four bus negedges, and only then reads the count and flags. That point lies far from the next timer edge, so each expected value is the arithmetic result after a known number of steps.

// File: rtl/async_timer_bridge.sv
`timescale 1ns/1ps
module async_timer_bridge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         tclk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [2:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic [2:0]   rd_addr,
  output logic [W-1:0] rd_data,
  output logic         irq
);
  localparam int N = 5;
  localparam int E = 3;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] hold [N];
  logic [N-1:0] req_tog, ack_s1, ack_s2, t_s1, t_s2;
  logic [E-1:0] ev_tog, ev_s1, ev_s2, ev_s3, flags, en;
  logic         coll;
  logic [W-1:0] cnt, cmp_a, cmp_b;
  logic         run, wrap;

  wire [N-1:0] busy   = req_tog ^ ack_s2;
  wire [N-1:0] sel    = wr_en ? (N'(1) << wr_addr) : '0;
  wire [N-1:0] acc    = sel & ~busy;
  wire         clash  = |(sel & busy);
  wire [E-1:0] clr    = (wr_en && wr_addr == 3'd6) ? wr_data[E-1:0] : '0;
  wire [E-1:0] ev_new = ev_s2 ^ ev_s3;

  wire [N-1:0] commit = t_s1 ^ t_s2;
  wire         step   = run && !commit[0];
  wire         quiet  = |commit[2:0];
  wire [W-1:0] cnt_nx = (wrap && cnt == cmp_a) ? '0 : cnt + 1'b1;

  assign irq = |(flags & en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) hold[i] <= '0;
      req_tog <= '0;
      ack_s1  <= '0;
      ack_s2  <= '0;
      ev_s1   <= '0;
      ev_s2   <= '0;
      ev_s3   <= '0;
      flags   <= '0;
      en      <= '0;
      coll    <= 1'b0;
    end else begin
      for (int i = 0; i < N; i++)
        if (acc[i]) begin
          hold[i]    <= wr_data;
          req_tog[i] <= ~req_tog[i];
        end
      ack_s1 <= t_s2;
      ack_s2 <= ack_s1;
      ev_s1  <= ev_tog;
      ev_s2  <= ev_s1;
      ev_s3  <= ev_s2;
      flags  <= (flags & ~clr) | ev_new;
      if (wr_en && wr_addr == 3'd7) en <= wr_data[E-1:0];
      if (clash) coll <= 1'b1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[5]) coll <= 1'b0;
    end
  end

  always_ff @(posedge tclk or negedge rst_n) begin
    if (!rst_n) begin
      t_s1   <= '0;
      t_s2   <= '0;
      cnt    <= '0;
      cmp_a  <= '0;
      cmp_b  <= '0;
      run    <= 1'b0;
      wrap   <= 1'b0;
      ev_tog <= '0;
    end else begin
      t_s1 <= req_tog;
      t_s2 <= t_s1;
      if (commit[0])   cnt <= hold[0];
      else if (run)    cnt <= cnt_nx;
      if (commit[1])   cmp_a <= hold[1];
      if (commit[2])   cmp_b <= hold[2];
      if (commit[3])   run   <= hold[3][0];
      if (commit[4])   wrap  <= hold[4][0];
      if (step && cnt == TOP)                  ev_tog[0] <= ~ev_tog[0];
      if (step && !quiet && cnt_nx == cmp_a)   ev_tog[1] <= ~ev_tog[1];
      if (step && !quiet && cnt_nx == cmp_b)   ev_tog[2] <= ~ev_tog[2];
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_data = cnt;
      3'd1:    rd_data = hold[1];
      3'd2:    rd_data = hold[2];
      3'd3:    rd_data = hold[3];
      3'd4:    rd_data = hold[4];
      3'd5:    rd_data = W'({coll, busy});
      3'd6:    rd_data = W'(flags);
      default: rd_data = W'(en);
    endcase
  end
endmodule

// File: rtl/async_timer_bridge_props.sv
`timescale 1ns/1ps
module async_timer_bridge_props #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         tclk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [2:0]   wr_addr,
  input logic [W-1:0] wr_data,
  input logic [4:0]   busy,
  input logic         coll,
  input logic [2:0]   flags,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic         run,
  input logic         commit0
);
  a_r3_busy_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((5'd1 << wr_addr) & ~busy) != 5'd0) |=> ((busy & $past(5'd1 << wr_addr)) != 5'd0));

  a_r5_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ((5'd1 << wr_addr) & busy) != 5'd0) |=> coll);

  a_r5_collision_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !(wr_en && wr_addr == 3'd5 && wr_data[5])) |=> coll);

  a_r10_flag_clears_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[0]) |-> $past(wr_en && wr_addr == 3'd6 && wr_data[0]));

  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != 3'd0));

  a_r7_count_moves_only_when_allowed: assert property (@(posedge tclk) disable iff (!rst_n)
    !$stable(cnt) |-> $past(run || commit0));
endmodule

bind async_timer_bridge async_timer_bridge_props #(.W(W)) u_props (
  .clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .coll(coll), .flags(flags), .irq(irq),
  .cnt(cnt), .run(run), .commit0(commit[0])
);

// File: tb/async_timer_bridge_bench.sv
`timescale 1ns/1ps
module async_timer_bridge_bench;
  logic       clk = 1'b0, tclk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;
  int checks = 0, fails = 0, tedges = 0, wr_edge = 0;

  async_timer_bridge #(.W(8)) u_async_timer_bridge (
    .clk(clk), .tclk(tclk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

  always #2.5 clk = ~clk;
  initial begin #1; forever #125 tclk = ~tclk; end
  always @(posedge tclk) tedges++;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.5;
    d = rd_data;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    wr_edge = tedges;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_commit(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] s, v;
    wr(a, d);
    rd(5, s);
    check("R3 busy set after write", int'(s[a]), 1);
    for (int i = 0; i < 2000 && s[a]; i++) begin
      @(negedge clk);
      rd(5, s);
    end
    check("R4 busy cleared", int'(s[a]), 0);
    check("R4 timer edges to commit", tedges - wr_edge, 2);
    if (a != 3'd0) begin
      rd(a, v);
      check("R2 holding readback", int'(v), int'(d));
    end
  endtask

  task automatic wait_t(input int k);
    repeat (k) @(posedge tclk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v, s, c;
    #700 rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset read", int'(v), 0);
    end
    check("R1 reset irq", int'(irq), 0);

    // R4 R7: count loads across a sweep of values while stopped
    for (int k = 0; k < 16; k++) begin
      wr_commit(0, 8'(k * 17));
      rd(0, v);
      check("R7 count load", int'(v), k * 17);
    end
    wr_commit(0, 8'd255);
    rd(0, v);
    check("R7 count load 255", int'(v), 255);

    // R5 R6: collision and independence
    wr(1, 8'h11);
    wr(1, 8'h22);
    wr(2, 8'h5A);
    rd(1, v); check("R5 ignored write keeps hold", int'(v), 'h11);
    rd(2, v); check("R6 other hold", int'(v), 'h5A);
    rd(5, s); check("R5 status busy and collision", int'(s), 'h26);
    for (int i = 0; i < 2000 && (s & 8'h1F) != 0; i++) begin
      @(negedge clk);
      rd(5, s);
    end
    check("R5 collision sticky after commit", int'(s), 'h20);
    rd(1, v); check("R5 hold after commit", int'(v), 'h11);
    wr(5, 8'h20);
    rd(5, s); check("R5 collision cleared", int'(s), 0);

    // R7 R8 R9 R10: run from 250 with compare A at 253
    wr_commit(1, 8'd253);
    wr_commit(0, 8'd250);
    wr_commit(3, 8'd1);
    for (int k = 1; k <= 8; k++) begin
      wait_t(1);
      rd(0, v); check("R7 counting", int'(v), (250 + k) % 256);
      rd(6, s); check("R8 R9 flags", int'(s), (k >= 6 ? 1 : 0) + (k >= 3 ? 2 : 0));
      check("R11 irq masked", int'(irq), 0);
    end
    wr(7, 8'h3);
    check("R11 irq enabled", int'(irq), 1);
    wr(7, 8'h4);
    check("R11 irq masked again", int'(irq), 0);
    wr(6, 8'h1);
    rd(6, s); check("R10 clear overflow only", int'(s), 2);
    wr(6, 8'h2);
    rd(6, s); check("R10 clear compare A", int'(s), 0);

    // R7: stopped count holds
    wr_commit(3, 8'd0);
    rd(0, c);
    wait_t(3);
    rd(0, v); check("R7 stopped holds", int'(v), int'(c));

    // R9: no compare flag on a commit edge
    wr_commit(3, 8'd1);
    wr_commit(0, 8'd10);
    rd(0, v); check("R7 load replaces count", int'(v), 10);
    wr(6, 8'h7);
    wr_commit(2, 8'd14);
    rd(0, v); check("R7 count after compare commit", int'(v), 12);
    wr_commit(2, 8'd120);
    rd(0, v); check("R9 count at suppressed edge", int'(v), 14);
    rd(6, s); check("R9 match suppressed on commit edge", int'(s[2]), 0);
    wr_commit(2, 8'd20);
    for (int k = 1; k <= 4; k++) begin
      wait_t(1);
      rd(0, v); check("R7 counting to B", int'(v), 16 + k);
      rd(6, s); check("R9 compare B", int'(s[2]), k == 4 ? 1 : 0);
    end

    // R12: restart after compare A
    wr_commit(3, 8'd0);
    wr_commit(0, 8'd0);
    wr_commit(1, 8'd4);
    wr_commit(4, 8'd1);
    wr(6, 8'h7);
    wr_commit(3, 8'd1);
    for (int k = 1; k <= 12; k++) begin
      wait_t(1);
      rd(0, v); check("R12 restart count", int'(v), k % 5);
      rd(6, s); check("R12 flags", int'(s), k >= 4 ? 2 : 0);
    end
    summary();
  end
endmodule